// File: doc/BRIEF.md
# ATM Cell Header Error Checker

This block checks the five-byte header of each received ATM cell against its header check byte. Each header arrives as one 40-bit word, marked by a valid strobe with a start-of-cell flag. The first header byte sits in bits 39:32 and the check byte in bits 7:0. A header with a single flipped bit is repaired and forwarded. A header with any other error is flagged for discard. The block also tracks runs of consecutive bad headers and raises a loss-of-cell-synchronisation flag when such a run grows long enough.

Payload beats share the same input word. They are beats with valid high and the start flag low. They are forwarded one cycle later and play no part in any decision. Results appear one clock after each input beat. Three saturating counters report good, repaired and discarded headers. The checker has two modes. In correction mode it repairs a single-bit error. In detection mode, which it enters after any errored header, it discards every errored header. One clean header returns it to correction mode.

Top module: `atm_hec_checker`

## Requirements
- R1: While reset is held and after it is released, with no input, out_valid, out_pass, out_drop, los and all three counters are zero.
- R2: A header whose bits 7:0 equal the CRC-8 (generator x^8+x^2+x+1, zero start, bits 39:8 fed most significant bit first) XORed with 0x55 is clean. One cycle later it appears unchanged on out_hdr with out_sop=1 and out_pass=1, and cnt_good increments.
- R3: In correction mode, a header with exactly one flipped bit appears one cycle later with that bit restored and out_pass=1, and cnt_corr increments.
- R4: A header whose error syndrome is nonzero and matches no single bit position is output unchanged with out_drop=1, and cnt_drop increments.
- R5: Any errored header switches the checker to detection mode. In detection mode a single-bit error is output unchanged with out_drop=1. A clean header switches the checker back to correction mode.
- R6: los rises one cycle after the 7th consecutive errored header, counting single-bit and multi-bit errors alike. A clean header resets the run to zero.
- R7: While los is high, it falls one cycle after the 6th consecutive clean header. Any errored header restarts that count.
- R8: A payload beat (valid=1, start=0) appears on out_pay one cycle later with out_pass=0 and out_drop=0. It changes neither los, the counters nor the mode. out_pay is zero on header beats, and out_hdr is zero on payload beats.
- R9: Each counter holds at its all-ones value instead of wrapping.
- R10: Every output header beat carries exactly one of out_pass and out_drop, and out_valid follows in_valid with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | Beat is a cell header |
| in_hdr | input | 40 | Header word, check byte in bits 7:0 |
| in_pay | input | PAY_W | Payload byte on payload beats |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | Output beat is a header |
| out_hdr | output | 40 | Checked and possibly repaired header |
| out_pay | output | PAY_W | Forwarded payload byte |
| out_pass | output | 1 | Header accepted |
| out_drop | output | 1 | Cell to be discarded |
| los | output | 1 | Loss of cell synchronisation |
| cnt_good | output | CNT_W | Saturating count of clean headers |
| cnt_corr | output | CNT_W | Saturating count of repaired headers |
| cnt_drop | output | CNT_W | Saturating count of discarded headers |

## Verification
The assertions assume that the start flag only matters when valid is high, and that every beat is handled in its own cycle with no back-pressure. The bench keeps to this by driving one beat per clock, or idling with valid low. It sets the start flag only on header beats. It corrupts headers only by XORing known one-bit or two-bit masks into a correctly coded word, so every injected error falls cleanly into the single-bit or multi-bit class.

// File: rtl/atm_hec_pkg.sv
package atm_hec_pkg;

   localparam int HDR_W  = 40;
   localparam int DATA_W = 32;
   localparam int HEC_W  = 8;
   localparam logic [HEC_W-1:0] GEN_POLY = 8'h07;

   typedef enum logic {
      MODE_CORRECT = 1'b0,
      MODE_DETECT  = 1'b1
   } hec_mode_e;

   typedef enum logic [1:0] {
      VERDICT_GOOD  = 2'd0,
      VERDICT_FIXED = 2'd1,
      VERDICT_DROP  = 2'd2
   } hec_verdict_e;

   // Bit-serial CRC-8 remainder of a 32-bit word, MSB first, zero start.
   function automatic logic [HEC_W-1:0] crc_of_word(input logic [DATA_W-1:0] w);
      logic [HEC_W-1:0] r;
      logic             fb;
      r = '0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb = r[HEC_W-1] ^ w[i];
         r  = {r[HEC_W-2:0], 1'b0};
         if (fb) r = r ^ GEN_POLY;
      end
      return r;
   endfunction

   // Syndrome produced by a lone flipped bit at header position pos.
   function automatic logic [HEC_W-1:0] lone_bit_syndrome(input int pos);
      logic [DATA_W-1:0] unit;
      if (pos < HEC_W) begin
         return HEC_W'(1) << pos;
      end
      unit = DATA_W'(1) << (pos - HEC_W);
      return crc_of_word(unit);
   endfunction

endpackage

// File: rtl/atm_hec_syndrome.sv
module atm_hec_syndrome
   import atm_hec_pkg::*;
#(
   parameter logic [HEC_W-1:0] HEC_COSET = 8'h55
) (
   input  logic [HDR_W-1:0] hdr,
   output logic [HEC_W-1:0] syn,
   output logic             clean
);
   logic [HEC_W-1:0] expect_hec;

   always_comb begin
      expect_hec = crc_of_word(hdr[HDR_W-1:HEC_W]) ^ HEC_COSET;
      syn        = expect_hec ^ hdr[HEC_W-1:0];
      clean      = (syn == '0);
   end
endmodule

// File: rtl/atm_hec_locator.sv
module atm_hec_locator
   import atm_hec_pkg::*;
#(
   parameter bit ENABLE_CORRECTION = 1'b1
) (
   input  logic [HEC_W-1:0] syn,
   output logic [HDR_W-1:0] flip,
   output logic             single
);
   generate
      if (ENABLE_CORRECTION) begin : g_locate
         for (genvar p = 0; p < HDR_W; p++) begin : g_pos
            localparam logic [HEC_W-1:0] KEY = lone_bit_syndrome(p);
            assign flip[p] = (syn == KEY);
         end
      end else begin : g_no_locate
         logic unused_syn;
         assign unused_syn = ^syn;
         assign flip       = '0;
      end
   endgenerate

   assign single = |flip;
endmodule

// File: rtl/atm_hec_sync_fsm.sv
module atm_hec_sync_fsm
   import atm_hec_pkg::*;
#(
   parameter int BAD_LIMIT  = 7,
   parameter int GOOD_LIMIT = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hdr_fire,
   input  logic         hdr_clean,
   input  logic         hdr_single,
   output hec_verdict_e verdict,
   output hec_mode_e    mode,
   output logic         los
);
   localparam int BAD_W  = $clog2(BAD_LIMIT + 1);
   localparam int GOOD_W = $clog2(GOOD_LIMIT + 1);
   localparam logic [BAD_W-1:0]  BAD_TRIP  = BAD_W'(BAD_LIMIT - 1);
   localparam logic [BAD_W-1:0]  BAD_CAP   = BAD_W'(BAD_LIMIT);
   localparam logic [GOOD_W-1:0] GOOD_TRIP = GOOD_W'(GOOD_LIMIT - 1);

   generate
      if (BAD_LIMIT < 2) begin : g_bad_limit_chk
         $error("BAD_LIMIT must be at least 2");
      end
      if (GOOD_LIMIT < 1) begin : g_good_limit_chk
         $error("GOOD_LIMIT must be at least 1");
      end
   endgenerate

   logic [BAD_W-1:0]  bad_run;
   logic [GOOD_W-1:0] good_run;

   always_comb begin
      if (hdr_clean)                             verdict = VERDICT_GOOD;
      else if (hdr_single && mode == MODE_CORRECT) verdict = VERDICT_FIXED;
      else                                       verdict = VERDICT_DROP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode     <= MODE_CORRECT;
         bad_run  <= '0;
         good_run <= '0;
         los      <= 1'b0;
      end else if (hdr_fire) begin
         if (hdr_clean) begin
            mode    <= MODE_CORRECT;
            bad_run <= '0;
            if (los) begin
               if (good_run >= GOOD_TRIP) begin
                  los      <= 1'b0;
                  good_run <= '0;
               end else begin
                  good_run <= good_run + 1'b1;
               end
            end else begin
               good_run <= '0;
            end
         end else begin
            mode     <= MODE_DETECT;
            good_run <= '0;
            if (bad_run != BAD_CAP) bad_run <= bad_run + 1'b1;
            if (!los && bad_run >= BAD_TRIP) los <= 1'b1;
         end
      end
   end

   AST_LOS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(los) |-> ($past(bad_run) == BAD_TRIP)); // R6

   AST_LOS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(los) |-> $past(hdr_fire && hdr_clean)); // R7

   AST_MODE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_fire && hdr_clean) |=> (mode == MODE_CORRECT)); // R5
endmodule

// File: rtl/atm_hec_sat_cnt.sv
module atm_hec_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = '1;

   generate
      if (W < 2) begin : g_width_chk
         $error("counter width must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt <= '0;
      else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
   end

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == TOP) |=> (cnt == TOP)); // R9

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R9
endmodule

// File: rtl/atm_hec_checker.sv
module atm_hec_checker
   import atm_hec_pkg::*;
#(
   parameter int               CNT_W             = 16,
   parameter int               PAY_W             = 8,
   parameter int               BAD_LIMIT         = 7,
   parameter int               GOOD_LIMIT        = 6,
   parameter logic [HEC_W-1:0] HEC_COSET         = 8'h55,
   parameter bit               ENABLE_CORRECTION = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic [HDR_W-1:0] in_hdr,
   input  logic [PAY_W-1:0] in_pay,
   output logic             out_valid,
   output logic             out_sop,
   output logic [HDR_W-1:0] out_hdr,
   output logic [PAY_W-1:0] out_pay,
   output logic             out_pass,
   output logic             out_drop,
   output logic             los,
   output logic [CNT_W-1:0] cnt_good,
   output logic [CNT_W-1:0] cnt_corr,
   output logic [CNT_W-1:0] cnt_drop
);
   localparam int N_CNT = 3;

   generate
      if (PAY_W < 1) begin : g_pay_chk
         $error("PAY_W must be at least 1");
      end
   endgenerate

   logic             hdr_fire, pay_fire;
   logic [HEC_W-1:0] syn;
   logic             clean, single;
   logic [HDR_W-1:0] flip;
   hec_verdict_e     verdict;
   hec_mode_e        mode;
   logic [N_CNT-1:0] cnt_inc;
   logic [CNT_W-1:0] cnt_val [N_CNT];

   assign hdr_fire = in_valid & in_sop;
   assign pay_fire = in_valid & ~in_sop;

   atm_hec_syndrome #(.HEC_COSET(HEC_COSET)) u_syn (
      .hdr   (in_hdr),
      .syn   (syn),
      .clean (clean)
   );

   atm_hec_locator #(.ENABLE_CORRECTION(ENABLE_CORRECTION)) u_loc (
      .syn    (syn),
      .flip   (flip),
      .single (single)
   );

   atm_hec_sync_fsm #(.BAD_LIMIT(BAD_LIMIT), .GOOD_LIMIT(GOOD_LIMIT)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .hdr_fire   (hdr_fire),
      .hdr_clean  (clean),
      .hdr_single (single),
      .verdict    (verdict),
      .mode       (mode),
      .los        (los)
   );

   assign cnt_inc[0] = hdr_fire && (verdict == VERDICT_GOOD);
   assign cnt_inc[1] = hdr_fire && (verdict == VERDICT_FIXED);
   assign cnt_inc[2] = hdr_fire && (verdict == VERDICT_DROP);

   generate
      for (genvar c = 0; c < N_CNT; c++) begin : g_cnt
         atm_hec_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[c]),
            .cnt   (cnt_val[c])
         );
      end
   endgenerate

   assign cnt_good = cnt_val[0];
   assign cnt_corr = cnt_val[1];
   assign cnt_drop = cnt_val[2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         out_hdr   <= '0;
         out_pay   <= '0;
         out_pass  <= 1'b0;
         out_drop  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_sop   <= hdr_fire;
         out_pass  <= hdr_fire && (verdict != VERDICT_DROP);
         out_drop  <= hdr_fire && (verdict == VERDICT_DROP);
         out_pay   <= pay_fire ? in_pay : '0;
         if (!hdr_fire)                     out_hdr <= '0;
         else if (verdict == VERDICT_FIXED) out_hdr <= in_hdr ^ flip;
         else                               out_hdr <= in_hdr;
      end
   end

   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sop) |-> ($countones({out_pass, out_drop}) == 1)); // R10

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R10

   AST_PAYLOAD_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sop) |-> (!out_pass && !out_drop)); // R8

   AST_PAYLOAD_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_sop) |=> ($stable(los) && $stable(cnt_good)
                                 && $stable(cnt_corr) && $stable(cnt_drop))); // R8

   AST_DETECT_NO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_fire && mode == MODE_DETECT) |=> (cnt_corr == $past(cnt_corr))); // R5

   AST_FIX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_fire |-> $onehot0(flip)); // R3
endmodule

// File: tb/atm_hec_checker_bench.sv
module atm_hec_checker_bench;
   localparam int CW   = 4;
   localparam int PW   = 8;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_sop = 1'b0;
   logic [39:0]   in_hdr = '0;
   logic [PW-1:0] in_pay = '0;
   logic          out_valid, out_sop, out_pass, out_drop, los;
   logic [39:0]   out_hdr;
   logic [PW-1:0] out_pay;
   logic [CW-1:0] cnt_good, cnt_corr, cnt_drop;

   always #5 clk = ~clk;

   atm_hec_checker #(.CNT_W(CW), .PAY_W(PW)) u_atm_hec_checker (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_hdr(in_hdr), .in_pay(in_pay), .out_valid(out_valid), .out_sop(out_sop),
      .out_hdr(out_hdr), .out_pay(out_pay), .out_pass(out_pass), .out_drop(out_drop),
      .los(los), .cnt_good(cnt_good), .cnt_corr(cnt_corr), .cnt_drop(cnt_drop)
   );

   typedef struct {
      logic          sop;
      logic [39:0]   hdr;
      logic [PW-1:0] pay;
      logic          pass;
      logic          drop;
      logic          los;
      int            cg, cc, cd;
      string         req;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad   = 0;
   bit   done  = 1'b0;

   // reference state
   bit m_detect = 0, m_los = 0;
   int m_bad = 0, m_good = 0, m_cg = 0, m_cc = 0, m_cd = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // byte-at-a-time reference check byte
   function automatic logic [7:0] ref_hec(input logic [31:0] w);
      logic [7:0] c;
      c = 8'h00;
      for (int b = 3; b >= 0; b--) begin
         c = c ^ w[b*8 +: 8];
         for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c ^ 8'h55;
   endfunction

   function automatic logic [39:0] mk_hdr(input logic [31:0] w);
      return {w, ref_hec(w)};
   endfunction

   function automatic bit hdr_ok(input logic [39:0] h);
      return ref_hec(h[39:8]) == h[7:0];
   endfunction

   task automatic send_hdr(input logic [31:0] w, input logic [39:0] err, input string req);
      exp_t e;
      logic [39:0] h, fixed;
      bit clean, single;
      h      = mk_hdr(w) ^ err;
      clean  = hdr_ok(h);
      single = 0;
      fixed  = h;
      if (!clean) begin
         for (int b = 0; b < 40; b++) begin
            if (!single && hdr_ok(h ^ (40'd1 << b))) begin
               single = 1;
               fixed  = h ^ (40'd1 << b);
            end
         end
      end
      e.sop = 1; e.pay = '0; e.req = req;
      if (clean) begin
         e.hdr = h; e.pass = 1; e.drop = 0;
         if (m_cg < CMAX) m_cg++;
         m_detect = 0; m_bad = 0;
         if (m_los) begin
            m_good++;
            if (m_good >= 6) begin m_los = 0; m_good = 0; end
         end
      end else begin
         if (single && !m_detect) begin
            e.hdr = fixed; e.pass = 1; e.drop = 0;
            if (m_cc < CMAX) m_cc++;
         end else begin
            e.hdr = h; e.pass = 0; e.drop = 1;
            if (m_cd < CMAX) m_cd++;
         end
         m_detect = 1; m_good = 0; m_bad++;
         if (m_bad >= 7) m_los = 1;
      end
      e.los = m_los; e.cg = m_cg; e.cc = m_cc; e.cd = m_cd;
      @(negedge clk);
      in_valid = 1; in_sop = 1; in_hdr = h; in_pay = 8'hEE;
      exp_q.push_back(e);
   endtask

   task automatic send_pay(input logic [PW-1:0] p, input string req);
      exp_t e;
      e.sop = 0; e.hdr = '0; e.pay = p; e.pass = 0; e.drop = 0; e.req = req;
      e.los = m_los; e.cg = m_cg; e.cc = m_cc; e.cd = m_cd;
      @(negedge clk);
      in_valid = 1; in_sop = 0; in_hdr = 40'hFF_FFFF_FFFF; in_pay = p;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 0; in_sop = 0; in_hdr = '0; in_pay = '0;
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            chk(0, "R10", "unexpected out_valid", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(out_sop == e.sop, e.req, "out_sop", out_sop, e.sop);
            chk(out_hdr == e.hdr, e.req, "out_hdr", out_hdr, e.hdr);
            chk(out_pay == e.pay, e.req, "out_pay", out_pay, e.pay);
            chk(out_pass == e.pass, e.req, "out_pass", out_pass, e.pass);
            chk(out_drop == e.drop, e.req, "out_drop", out_drop, e.drop);
            chk(los == e.los, e.req, "los", los, e.los);
            chk(int'(cnt_good) == e.cg, e.req, "cnt_good", cnt_good, e.cg);
            chk(int'(cnt_corr) == e.cc, e.req, "cnt_corr", cnt_corr, e.cc);
            chk(int'(cnt_drop) == e.cd, e.req, "cnt_drop", cnt_drop, e.cd);
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state while held
      chk(!out_valid && !out_pass && !out_drop && !los, "R1", "flags in reset",
          {out_valid, out_pass, out_drop, los}, 0);
      chk(cnt_good == 0 && cnt_corr == 0 && cnt_drop == 0, "R1", "counters in reset",
          {cnt_good, cnt_corr, cnt_drop}, 0);
      @(negedge clk) rst_n = 1;
      idle(2);
      chk(!out_valid && !los && cnt_good == 0, "R1", "idle after reset",
          {out_valid, los, cnt_good}, 0);

      // R2 clean headers, R8 payload interleaved
      send_hdr(32'h0000_0000, '0, "R2");
      send_pay(8'hA5, "R8");
      send_hdr(32'h00A0_1230, '0, "R2");
      send_hdr(32'hFFFF_FFF0, '0, "R2");
      send_pay(8'h3C, "R8");
      idle(1);

      // R3 single-bit repair in correction mode, R5 detection mode
      send_hdr(32'h1234_5678, 40'h80_0000_0000, "R3");
      send_hdr(32'h1234_5678, 40'h00_0000_0001, "R5");
      send_hdr(32'h0ABC_DEF0, '0, "R5");
      send_hdr(32'h0ABC_DEF0, 40'h00_0010_0000, "R3");
      send_hdr(32'h5555_AAAA, '0, "R2");
      send_hdr(32'h5555_AAAA, 40'h00_0000_0080, "R3");
      send_hdr(32'h7777_0000, '0, "R5");

      // R4 multi-bit errors
      send_hdr(32'h0101_0101, 40'h00_0000_0003, "R4");
      send_hdr(32'h0202_0202, '0, "R2");
      send_hdr(32'h0303_0303, 40'h81_0000_0000, "R4");
      send_hdr(32'h0404_0404, '0, "R2");

      // R8 payload with arbitrary contents does not disturb state
      for (int i = 0; i < 6; i++) send_pay(PW'(8'hF0 + i), "R8");
      idle(1);

      // R6 six bad then a good: no loss; then seven bad: loss
      for (int i = 0; i < 6; i++) send_hdr(32'h1000_0000 + i, 40'h00_0000_0100 << i, "R6");
      send_hdr(32'h2000_0000, '0, "R6");
      for (int i = 0; i < 7; i++) send_hdr(32'h3000_0000 + i, 40'h00_0000_0006, "R6");
      send_pay(8'h11, "R8");
      // R7 five good then bad restarts the count, then six good clear
      for (int i = 0; i < 5; i++) send_hdr(32'h4000_0000 + i, '0, "R7");
      send_hdr(32'h4100_0000, 40'h00_0400_0000, "R7");
      for (int i = 0; i < 6; i++) send_hdr(32'h4200_0000 + i, '0, "R7");
      send_hdr(32'h4300_0000, 40'h00_0000_0020, "R3");

      // R9 saturate all counters
      for (int i = 0; i < 18; i++) send_hdr(32'h5000_0000 + i, '0, "R9");
      for (int i = 0; i < 18; i++) send_hdr(32'h6000_0000 + i, 40'h00_0000_0011, "R9");
      for (int i = 0; i < 20; i++) begin
         send_hdr(32'h7000_0000 + i, '0, "R9");
         send_hdr(32'h7100_0000 + i, 40'h00_0002_0000, "R9");
      end
      idle(3);

      chk(exp_q.size() == 0, "R10", "unmatched expected beats", exp_q.size(), 0);
      chk(cnt_good == CW'(CMAX) && cnt_drop == CW'(CMAX), "R9", "final saturation",
          {cnt_good, cnt_drop}, {CW'(CMAX), CW'(CMAX)});
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule